// File: doc/BRIEF.md
# Dual-Channel Programmable Timer/Counter

This peripheral holds two independent counting channels behind a single-cycle register bus. Each channel has three word registers: a control/status word, a preset (load) value, and the live counter. A channel can count up or down, be preset from its load register, stop on command, and signal expiry through a sticky status flag. Optionally it reloads and keeps running after expiry.

Software typically uses one channel as a periodic down-counting tick source with interrupts enabled. The other channel free-runs upward as a timestamp that can be read at any moment. An interrupt is acknowledged by writing back the control word that was read, since a one in the status position clears it. A single registered interrupt line combines both channels.

Reads are combinational from the current address. Writes take effect at the next rising clock edge. Reset is asynchronous and active low. Its release is synchronised inside the block, and the block leaves reset two clock edges after reset is released.

Top module: `tmr_dual`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low.
- R2: Channel c (0 or 1) decodes at word offsets 0x00+16c (control), 0x04+16c (load) and 0x08+16c (counter). Offsets 0x0C and 0x1C, and any address with bit 1 or bit 0 set, read as zero and ignore writes. The load register holds the low CNT_W bits of the written data and reads back zero-extended.
- R3: Control bits 0,1,2,3,4,5,6,7,9,10 read back exactly as last written. Bit 8 reads the status flag, and bits 31..11 read zero. The bit meanings are: bit 1 = count down (0 = up), bit 4 = reload on expiry, bit 5 = preset, bit 6 = interrupt enable, bit 7 = run. Bits 0, 2, 3, 9 and 10 are stored only.
- R4: While bit 5 is 1, each clock copies the load register into the counter. Clearing it lets the counter run from that value.
- R5: With bit 7 = 1, bit 5 = 0 and bit 1 = 1, the counter decrements once per clock. Stepping from 0 is an expiry. With bit 4 set, the counter reloads from the load register and sets status in the same clock, which gives one event every load+1 clocks.
- R6: With bit 1 = 0 the counter increments once per clock. Stepping from all-ones is an expiry. With bit 4 set, the counter reloads from the load register, so a load value of zero gives a modulo-2^CNT_W free-run. Status is set in the same clock.
- R7: On expiry with bit 4 = 0, the counter holds its expiry value, status is set, and the channel clears its own bit 7.
- R8: While bit 7 = 0 and bit 5 = 0, the counter holds its value.
- R9: The status flag is sticky. Writing a control word with bit 8 = 1 clears it, and writing bit 8 = 0 leaves it unchanged.
- R10: The interrupt output is a register loaded each clock with the OR over both channels of (status AND bit 6). It therefore follows the flags one clock later.
- R11: Writes to a counter register are ignored.
- R12: Each channel's registers and counting are unaffected by accesses to the other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with CNT_W = 8 and the default two channels. With this width, up-counting expiry at all-ones, the wrap through a zero load, and one-shot stops at all-ones all occur within a few hundred clocks, so long random runs hit them many times. The small width also makes random load values close to the counter range, so down-count reloads, preset holds and interrupt acknowledges that coincide with an expiry all show up frequently.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned CTRL_W = 11;

  localparam int unsigned B_DOWN   = 1;
  localparam int unsigned B_RELOAD = 4;
  localparam int unsigned B_PRESET = 5;
  localparam int unsigned B_IE     = 6;
  localparam int unsigned B_RUN    = 7;
  localparam int unsigned B_FLAG   = 8;

  typedef enum logic [1:0] {
    RS_CTRL  = 2'd0,
    RS_LOAD  = 2'd1,
    RS_COUNT = 2'd2,
    RS_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned ADDR_W = CH_W + 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output reg_sel_e          sel_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [NUM_CH-1:0] wr_ctrl_o,
  output logic [NUM_CH-1:0] wr_load_o
);
  logic ch_ok;

  assign ch_o = addr_i[ADDR_W-1:4];

  generate
    if (NUM_CH == (2 ** CH_W)) begin : g_full
      assign ch_ok = 1'b1;
    end else begin : g_part
      assign ch_ok = (ch_o < CH_W'(NUM_CH));
    end
  endgenerate

  always_comb begin
    sel_o = RS_NONE;
    if ((addr_i[1:0] == 2'b00) && ch_ok) begin
      case (addr_i[3:2])
        2'd0:    sel_o = RS_CTRL;
        2'd1:    sel_o = RS_LOAD;
        2'd2:    sel_o = RS_COUNT;
        default: sel_o = RS_NONE;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
    assign wr_ctrl_o[c] = we_i && (sel_o == RS_CTRL) && (ch_o == CH_W'(c));
    assign wr_load_o[c] = we_i && (sel_o == RS_LOAD) && (ch_o == CH_W'(c));
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl_i,
  input  logic             wr_load_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] ctrl_rd_o,
  output logic [BUS_W-1:0] load_rd_o,
  output logic [BUS_W-1:0] cnt_rd_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  load_q, cnt_q, cnt_d;
  logic              cnt_ce;
  logic              run, at_end, expire;

  always_comb begin
    run    = ctrl_q[B_RUN] && !ctrl_q[B_PRESET];
    at_end = ctrl_q[B_DOWN] ? (cnt_q == '0) : (cnt_q == CNT_MAX);
    expire = run && at_end;

    cnt_ce = ctrl_q[B_PRESET] || run;
    cnt_d  = cnt_q;
    if (ctrl_q[B_PRESET]) begin
      cnt_d = load_q;
    end else if (expire) begin
      cnt_d = ctrl_q[B_RELOAD] ? load_q : cnt_q;
    end else if (ctrl_q[B_DOWN]) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end

    ctrl_d = ctrl_q;
    if (wr_ctrl_i) begin
      ctrl_d = wdata_i[CTRL_W-1:0];
    end else if (expire && !ctrl_q[B_RELOAD]) begin
      ctrl_d[B_RUN] = 1'b0;
    end
    ctrl_d[B_FLAG] = (ctrl_q[B_FLAG] && !(wr_ctrl_i && wdata_i[B_FLAG])) || expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (wr_load_i) begin
      load_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[CTRL_W-1:0] = ctrl_q;
    load_rd_o = '0;
    load_rd_o[CNT_W-1:0] = load_q;
    cnt_rd_o = '0;
    cnt_rd_o[CNT_W-1:0] = cnt_q;
  end

  assign flag_o = ctrl_q[B_FLAG] && ctrl_q[B_IE];

  // R4: preset copies the load register on the following edge
  p_preset_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[B_PRESET] |=> (cnt_q == $past(load_q)));

  // R8: a stopped channel keeps its count
  p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_RUN] && !ctrl_q[B_PRESET]) |=> $stable(cnt_q));

  // R5: one decrement per clock away from zero
  p_down_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctrl_q[B_DOWN] && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6: up-count reload at all-ones raises the flag
  p_up_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ctrl_q[B_DOWN] && (cnt_q == CNT_MAX) && ctrl_q[B_RELOAD])
      |=> (ctrl_q[B_FLAG] && (cnt_q == $past(load_q))));

  // R7: one-shot expiry stops the channel
  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q[B_RELOAD] && !wr_ctrl_i) |=> (!ctrl_q[B_RUN] && ctrl_q[B_FLAG]));

  // R9: flag stays set unless cleared by a write of one
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_FLAG] && !(wr_ctrl_i && wdata_i[B_FLAG])) |=> ctrl_q[B_FLAG]);
endmodule

// File: rtl/tmr_irq_merge.sv
module tmr_irq_merge #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] flags_i,
  output logic              irq_o
);
  logic irq_d, irq_q;

  always_comb begin
    irq_d = |flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R10: interrupt rises only after some flag was pending
  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(|flags_i));

  // R10: interrupt drops one clock after all flags clear
  p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i == '0) |=> !irq_q);
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned ADDR_W = CH_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  reg_sel_e          sel;
  logic [CH_W-1:0]   ch;
  logic [NUM_CH-1:0] wr_ctrl, wr_load, flags;
  logic [BUS_W-1:0]  ctrl_rd [NUM_CH];
  logic [BUS_W-1:0]  load_rd [NUM_CH];
  logic [BUS_W-1:0]  cnt_rd  [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  tmr_decode #(.NUM_CH(NUM_CH)) i_decode (
    .addr_i    (bus_addr),
    .we_i      (bus_we),
    .sel_o     (sel),
    .ch_o      (ch),
    .wr_ctrl_o (wr_ctrl),
    .wr_load_o (wr_load)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) i_channel (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .wr_ctrl_i (wr_ctrl[c]),
      .wr_load_i (wr_load[c]),
      .wdata_i   (bus_wdata),
      .ctrl_rd_o (ctrl_rd[c]),
      .load_rd_o (load_rd[c]),
      .cnt_rd_o  (cnt_rd[c]),
      .flag_o    (flags[c])
    );
  end

  always_comb begin
    case (sel)
      RS_CTRL:  bus_rdata = ctrl_rd[ch];
      RS_LOAD:  bus_rdata = load_rd[ch];
      RS_COUNT: bus_rdata = cnt_rd[ch];
      default:  bus_rdata = '0;
    endcase
  end

  tmr_irq_merge #(.NUM_CH(NUM_CH)) i_irq (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .flags_i (flags),
    .irq_o   (irq_o)
  );

  // R2: holes in the map read zero
  p_hole_zero_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (sel == RS_NONE) |-> (bus_rdata == '0));

  // R11: counter-register writes leave no write strobe on any channel
  p_cnt_write_ignored_r11: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_we && (sel == RS_COUNT)) |-> ((wr_ctrl == '0) && (wr_load == '0)));
endmodule

// File: tb/test_tmr_dual.sv
module test_tmr_dual;
  localparam int unsigned CW = 8;
  localparam logic [CW-1:0] CMAX = '1;

  logic        clk;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int unsigned n_cmp;
  int unsigned n_bad;
  logic [31:0] last_rd;

  logic [10:0]   m_ctrl [2];
  logic [CW-1:0] m_load [2];
  logic [CW-1:0] m_cnt  [2];
  logic          m_irq;

  tmr_dual #(.NUM_CH(2), .CNT_W(CW)) i_tmr_dual (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [4:0] a);
    logic [31:0] r;
    r = '0;
    if (a[1:0] == 2'b00) begin
      case (a[3:2])
        2'd0: r[10:0]   = m_ctrl[a[4]];
        2'd1: r[CW-1:0] = m_load[a[4]];
        2'd2: r[CW-1:0] = m_cnt[a[4]];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic model_step(input logic [4:0] a, input logic w, input logic [31:0] d);
    logic [10:0]   nc [2];
    logic [CW-1:0] nl [2];
    logic [CW-1:0] nn [2];
    logic          irq_n;
    irq_n = 1'b0;
    for (int c = 0; c < 2; c++) begin
      logic wc, wl, run, ex, endv;
      wc   = w && (a[1:0] == 2'b00) && (a[3:2] == 2'd0) && (a[4] == c[0]);
      wl   = w && (a[1:0] == 2'b00) && (a[3:2] == 2'd1) && (a[4] == c[0]);
      run  = m_ctrl[c][7] && !m_ctrl[c][5];
      endv = m_ctrl[c][1] ? (m_cnt[c] == '0) : (m_cnt[c] == CMAX);
      ex   = run && endv;
      irq_n = irq_n | (m_ctrl[c][8] & m_ctrl[c][6]);
      if (m_ctrl[c][5])      nn[c] = m_load[c];
      else if (!run)         nn[c] = m_cnt[c];
      else if (ex)           nn[c] = m_ctrl[c][4] ? m_load[c] : m_cnt[c];
      else if (m_ctrl[c][1]) nn[c] = m_cnt[c] - 1'b1;
      else                   nn[c] = m_cnt[c] + 1'b1;
      nc[c] = m_ctrl[c];
      if (wc) nc[c] = d[10:0];
      else if (ex && !m_ctrl[c][4]) nc[c][7] = 1'b0;
      nc[c][8] = (m_ctrl[c][8] && !(wc && d[8])) || ex;
      nl[c] = wl ? d[CW-1:0] : m_load[c];
    end
    for (int c = 0; c < 2; c++) begin
      m_ctrl[c] = nc[c];
      m_load[c] = nl[c];
      m_cnt[c]  = nn[c];
    end
    m_irq = irq_n;
  endtask

  task automatic tick(input logic [4:0] a, input logic w, input logic [31:0] d, input string tag);
    @(negedge clk);
    bus_addr  = a;
    bus_we    = w;
    bus_wdata = d;
    #1;
    last_rd = bus_rdata;
    chk(tag, bus_rdata, model_read(a));
    chk("R10 irq", {31'b0, irq_o}, {31'b0, m_irq});
    model_step(a, w, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int first4, second4;
    logic [31:0] held;
    n_cmp = 0;
    n_bad = 0;
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < 2; c++) begin
      m_ctrl[c] = '0; m_load[c] = '0; m_cnt[c] = '0;
    end
    m_irq = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    tick(5'h00, 0, 0, "R1"); chk("R1 ctrl0", last_rd, 32'h0);
    tick(5'h08, 0, 0, "R1"); chk("R1 cnt0", last_rd, 32'h0);
    tick(5'h10, 0, 0, "R1"); chk("R1 ctrl1", last_rd, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R3: control readback
    tick(5'h00, 1, 32'h1, "R3");
    tick(5'h00, 0, 0, "R3"); chk("R3 mode bit", last_rd, 32'h1);
    tick(5'h00, 1, 32'h60D, "R3");
    tick(5'h00, 0, 0, "R3"); chk("R3 stored bits", last_rd, 32'h60D);
    tick(5'h00, 1, 32'hFFFF_F000, "R3");
    tick(5'h00, 0, 0, "R3"); chk("R3 upper zero", last_rd, 32'h0);

    // R2 / R12: map, holes, independence
    tick(5'h04, 1, 32'h33, "R2");
    tick(5'h04, 0, 0, "R2"); chk("R2 load0", last_rd, 32'h33);
    tick(5'h14, 0, 0, "R12"); chk("R12 load1 untouched", last_rd, 32'h0);
    tick(5'h0C, 1, 32'hFFFF_FFFF, "R2"); 
    tick(5'h0C, 0, 0, "R2"); chk("R2 hole 0C", last_rd, 32'h0);
    tick(5'h1C, 0, 0, "R2"); chk("R2 hole 1C", last_rd, 32'h0);
    tick(5'h01, 0, 0, "R2"); chk("R2 misaligned", last_rd, 32'h0);

    // R4: preset
    tick(5'h00, 1, 32'h20, "R4");
    tick(5'h08, 0, 0, "R4");
    tick(5'h08, 0, 0, "R4"); chk("R4 preset copy", last_rd, 32'h33);
    tick(5'h04, 1, 32'h4, "R4");
    tick(5'h08, 0, 0, "R4");
    tick(5'h08, 0, 0, "R4"); chk("R4 preset follows load", last_rd, 32'h4);

    // R5: periodic down count, period load+1
    tick(5'h00, 1, 32'hD2, "R5");
    first4 = -1; second4 = -1;
    for (int i = 0; i < 14; i++) begin
      tick(5'h08, 0, 0, "R5");
      if (last_rd == 32'h4) begin
        if (first4 < 0) first4 = i;
        else if (second4 < 0) second4 = i;
      end
    end
    chk("R5 period", 32'(second4 - first4), 32'd5);
    chk("R10 irq raised", {31'b0, irq_o}, 32'h1);

    // R8: stop holds count
    tick(5'h00, 1, 32'h52, "R8");
    tick(5'h08, 0, 0, "R8"); held = last_rd;
    tick(5'h08, 0, 0, "R8"); chk("R8 hold", last_rd, held);
    tick(5'h00, 1, 32'h100, "R9");
    tick(5'h00, 0, 0, "R9"); chk("R9 clear ch0", last_rd, 32'h0);

    // R7: one-shot up count on channel 1
    tick(5'h14, 1, 32'd250, "R7");
    tick(5'h10, 1, 32'h20, "R7");
    tick(5'h10, 1, 32'h80, "R7");
    for (int i = 0; i < 20; i++) tick(5'h18, 0, 0, "R7");
    chk("R7 holds max", last_rd, 32'hFF);
    tick(5'h10, 0, 0, "R7"); chk("R7 run cleared flag set", last_rd, 32'h100);

    // R11: counter write ignored
    tick(5'h18, 1, 32'h55, "R11");
    tick(5'h18, 0, 0, "R11"); chk("R11 counter write", last_rd, 32'hFF);

    // R9: sticky flag
    tick(5'h10, 1, 32'h0, "R9");
    tick(5'h10, 0, 0, "R9"); chk("R9 write zero keeps", last_rd, 32'h100);
    tick(5'h10, 1, 32'h100, "R9");
    tick(5'h10, 0, 0, "R9"); chk("R9 write one clears", last_rd, 32'h0);

    // R6: up-count wrap via zero load
    tick(5'h14, 1, 32'h0, "R6");
    tick(5'h10, 1, 32'h90, "R6");
    tick(5'h18, 0, 0, "R6");
    tick(5'h10, 0, 0, "R6"); chk("R6 wrap flag", last_rd, 32'h190);
    tick(5'h18, 0, 0, "R6"); chk("R6 wrapped count", last_rd, 32'h1);

    // Random phase against the bench model
    for (int i = 0; i < 3000; i++) begin
      logic [4:0]  a;
      logic        w;
      logic [31:0] d;
      int          pick;
      pick = int'($urandom % 9);
      case (pick)
        0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08; 3: a = 5'h10;
        4: a = 5'h14; 5: a = 5'h18; 6: a = 5'h0C; 7: a = 5'h1C;
        default: a = 5'($urandom);
      endcase
      w = ($urandom % 3) == 0;
      d = $urandom;
      if (a[3:2] == 2'd0) begin
        d[5] = ($urandom % 8) == 0;
        d[7] = ($urandom % 4) != 0;
      end else if (a[3:2] == 2'd1 && ($urandom % 4) != 0) begin
        d = $urandom % 24;
      end
      case (a[3:2])
        2'd0:    tick(a, w, d, (a[1:0] == 0) ? "R3 ctrl" : "R2 hole");
        2'd1:    tick(a, w, d, (a[1:0] == 0) ? "R2 load" : "R2 hole");
        2'd2:    tick(a, w, d, (a[1:0] == 0) ? "R5 R6 R12 count" : "R2 hole");
        default: tick(a, w, d, "R2 hole");
      endcase
    end

    @(negedge clk);
    bus_we = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule